// File: doc/BRIEF.md
# Instruction Hazard Pattern Checker

This block watches an in-order stream of decoded instruction descriptors, at most one per clock. Each descriptor gives an instruction class, an optional scalar register read and write, flags for reading or writing the EXEC mask, the instruction's byte offset inside its code block, and an immediate operand. The checker flags an instruction when it completes one of seven known hardware hazard patterns and no mitigating instruction has come between the two halves. It does not repair the stream. It only reports, so that a compiler back end or a trace monitor can insert the missing mitigation.

Every rule keeps its own pending state, and only that rule's own mitigation clears it. Two rules keep a pending bit for each scalar register index. A later trigger on the same index simply sets the bit again. The result is a registered vector with one bit per rule. It appears one cycle after the instruction is accepted and holds at most one set bit.

Top module: `hz_checker`

## Requirements
- R1: Class codes on `in_class`: 0 VALU, 1 VALU no-op, 2 vector compare, 3 permlane, 4 SALU, 5 SALU skip-set, 6 SALU version, 7 other program-control (SOPP), 8 branch, 9 SMEM, 10 VMEM, 11 FLAT, 12 GLOBAL, 13 SCRATCH, 14 DS, 15 LGKM-counter wait, 16 other counter wait, 17 vector-store-counter wait, 18 dependency-counter wait. Codes 0-3 are VALU. Codes 15-18 are waits. `hazard` is registered and reflects the instruction accepted at the previous edge. It is zero after a cycle with `in_valid` low.
- R2: Bit 0 is set when a memory instruction (10-14) reads a scalar register index, or reads EXEC, and a later SALU (4-6) or SMEM (9) writes the same index, or writes EXEC. Any VALU or any wait in between clears all of this pending state.
- R3: Bit 1 is set when SMEM reads a scalar index and a later VALU writes that index. Only class 4 or an LGKM wait (15) clears it. Skip-set (5), version (6) and other counter waits (16) leave it pending.
- R4: Bit 2 is set when a permlane follows a vector compare with no VALU between them. A VALU no-op (1) does not clear it.
- R5: Bit 3 is set when a non-VALU instruction reads EXEC and a later VALU writes EXEC. A VALU that writes a scalar register clears it, and so does a dependency-counter wait whose `in_imm` is 0xFFFE. Any other operand leaves it pending.
- R6: Bit 4 is set on DS after a VMEM/GLOBAL/SCRATCH and a later branch. It is also set on VMEM/GLOBAL/SCRATCH after a DS and a later branch. Only a vector-store-counter wait with `in_imm` zero clears this. A nonzero count does not.
- R7: Bit 5 is set for a branch whose `in_offset` equals 0x3F.
- R8: Bit 6 is set for a FLAT instruction whose low 12 bits of `in_imm` are nonzero. GLOBAL and SCRATCH never set it, and bits above bit 11 are ignored.
- R9: Synchronous `rst` clears the output and all pending state. `blk_start` clears all pending state before the instruction presented in the same cycle is evaluated.
- R10: When several rules fire at once, only the lowest-numbered bit is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_start | input | 1 | New code block; flushes pending state |
| in_valid | input | 1 | Descriptor present this cycle |
| in_class | input | 5 | Instruction class code (R1) |
| in_srd_vld | input | 1 | Scalar register read present |
| in_srd | input | 7 | Scalar register index read |
| in_swr_vld | input | 1 | Scalar register write present |
| in_swr | input | 7 | Scalar register index written |
| in_exec_rd | input | 1 | Instruction reads EXEC |
| in_exec_wr | input | 1 | Instruction writes EXEC |
| in_offset | input | 16 | Byte offset within code block |
| in_imm | input | 16 | Immediate / wait operand |
| hazard | output | 7 | Registered one-hot hazard flags |

## Verification
The assertions assume that every input is known and settled at each rising edge, and that `rst` is held for at least one edge before the stream starts. They also rely on program-control instructions (class 7) never completing any rule. The bench drives all inputs on the falling edge. It draws classes only from the 19 defined codes and keeps register indices within 0-7, so that pending entries are hit often. It places offset 0x3F, wait operands 0 and 0xFFFE, and occasional block starts and idle cycles, so that each rule's mitigation and flush paths are exercised as well as its trigger.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int CLS_W     = 5;
    localparam int NUM_RULES = 7;

    // rule bit positions in the hazard vector (lowest has priority)
    localparam int RB_MEMSCAL = 0;
    localparam int RB_SMEMVAL = 1;
    localparam int RB_CMPPERM = 2;
    localparam int RB_EXECWAR = 3;
    localparam int RB_LDSBR   = 4;
    localparam int RB_BROFS   = 5;
    localparam int RB_FLATOFS = 6;

    typedef enum logic [CLS_W-1:0] {
        C_VALU    = 5'd0,
        C_VNOP    = 5'd1,
        C_VCMP    = 5'd2,
        C_PERM    = 5'd3,
        C_SALU    = 5'd4,
        C_SSKIP   = 5'd5,
        C_SVER    = 5'd6,
        C_SOPP    = 5'd7,
        C_BRANCH  = 5'd8,
        C_SMEM    = 5'd9,
        C_VMEM    = 5'd10,
        C_FLAT    = 5'd11,
        C_GLOBAL  = 5'd12,
        C_SCRATCH = 5'd13,
        C_DS      = 5'd14,
        C_WLGKM   = 5'd15,
        C_WCNT    = 5'd16,
        C_WVS     = 5'd17,
        C_WDEP    = 5'd18
    } cls_e;

    typedef struct packed {
        logic valu;
        logic vnop;
        logic vcmp;
        logic perm;
        logic salu;
        logic salu_clr;
        logic smem;
        logic memrd;
        logic vmx;
        logic ds;
        logic branch;
        logic flat;
        logic wait_any;
        logic vs_zero;
        logic dep_clear;
    } dec_t;

endpackage

// File: rtl/hz_decode.sv
module hz_decode
    import hz_pkg::*;
#(
    parameter int          IMM_W   = 16,
    parameter logic [15:0] DEP_CLR = 16'hFFFE
) (
    input  logic [CLS_W-1:0] cls,
    input  logic [IMM_W-1:0] imm,
    output dec_t             dec
);
    cls_e c;

    always_comb begin
        c             = cls_e'(cls);
        dec           = '0;
        dec.valu      = (c == C_VALU) || (c == C_VNOP) || (c == C_VCMP) || (c == C_PERM);
        dec.vnop      = (c == C_VNOP);
        dec.vcmp      = (c == C_VCMP);
        dec.perm      = (c == C_PERM);
        dec.salu      = (c == C_SALU) || (c == C_SSKIP) || (c == C_SVER);
        dec.salu_clr  = (c == C_SALU) || (c == C_WLGKM);
        dec.smem      = (c == C_SMEM);
        dec.vmx       = (c == C_VMEM) || (c == C_GLOBAL) || (c == C_SCRATCH);
        dec.ds        = (c == C_DS);
        dec.flat      = (c == C_FLAT);
        dec.memrd     = dec.vmx || dec.ds || dec.flat;
        dec.branch    = (c == C_BRANCH);
        dec.wait_any  = (c == C_WLGKM) || (c == C_WCNT) || (c == C_WVS) || (c == C_WDEP);
        dec.vs_zero   = (c == C_WVS) && (imm == '0);
        dec.dep_clear = (c == C_WDEP) && (imm == DEP_CLR[IMM_W-1:0]);
    end

endmodule

// File: rtl/hz_reg_table.sv
module hz_reg_table #(
    parameter int NREG  = 128,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             step,
    input  logic             clr,
    input  logic             arm_vld,
    input  logic [IDX_W-1:0] arm_idx,
    input  logic             arm_ex,
    input  logic             probe_vld,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic             probe_ex,
    output logic             hit
);
    typedef struct packed {
        logic [NREG-1:0] regs;
        logic            ex;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        hit = step && !flush &&
              ((probe_vld && tbl_q.regs[probe_idx]) || (probe_ex && tbl_q.ex));
        tbl_d = flush ? '0 : tbl_q;
        if (step) begin
            if (clr) begin
                tbl_d = '0;
            end
            if (arm_vld) begin
                tbl_d.regs[arm_idx] = 1'b1;
            end
            if (arm_ex) begin
                tbl_d.ex = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/hz_checker.sv
module hz_checker
    import hz_pkg::*;
#(
    parameter int          NREG       = 128,
    parameter int          OFS_W      = 16,
    parameter int          IMM_W      = 16,
    parameter int          FLAT_OFS_W = 12,
    parameter logic [15:0] BAD_BR_OFS = 16'h003F,
    localparam int         IDX_W      = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 blk_start,
    input  logic                 in_valid,
    input  logic [CLS_W-1:0]     in_class,
    input  logic                 in_srd_vld,
    input  logic [IDX_W-1:0]     in_srd,
    input  logic                 in_swr_vld,
    input  logic [IDX_W-1:0]     in_swr,
    input  logic                 in_exec_rd,
    input  logic                 in_exec_wr,
    input  logic [OFS_W-1:0]     in_offset,
    input  logic [IMM_W-1:0]     in_imm,
    output logic [NUM_RULES-1:0] hazard
);
    typedef struct packed {
        logic                 vcmp;   // compare awaiting a clearing VALU
        logic                 exw;    // EXEC read awaiting clear
        logic                 pv;     // vector memory seen
        logic                 pd;     // DS seen
        logic                 vb;     // vector memory then branch
        logic                 db;     // DS then branch
        logic [NUM_RULES-1:0] haz;
    } st_t;

    st_t  st_d, st_q;
    st_t  base;
    dec_t dec;
    logic hit_memscal, hit_smemval;
    logic [NUM_RULES-1:0] raw;

    hz_decode #(.IMM_W(IMM_W)) u_dec (
        .cls (in_class),
        .imm (in_imm),
        .dec (dec)
    );

    // memory read of scalar/EXEC, later scalar write
    hz_reg_table #(.NREG(NREG)) u_tbl_memscal (
        .clk       (clk),
        .rst       (rst),
        .flush     (blk_start),
        .step      (in_valid),
        .clr       (dec.valu || dec.wait_any),
        .arm_vld   (dec.memrd && in_srd_vld),
        .arm_idx   (in_srd),
        .arm_ex    (dec.memrd && in_exec_rd),
        .probe_vld ((dec.salu || dec.smem) && in_swr_vld),
        .probe_idx (in_swr),
        .probe_ex  ((dec.salu || dec.smem) && in_exec_wr),
        .hit       (hit_memscal)
    );

    // scalar memory read, later vector write
    hz_reg_table #(.NREG(NREG)) u_tbl_smemval (
        .clk       (clk),
        .rst       (rst),
        .flush     (blk_start),
        .step      (in_valid),
        .clr       (dec.salu_clr),
        .arm_vld   (dec.smem && in_srd_vld),
        .arm_idx   (in_srd),
        .arm_ex    (1'b0),
        .probe_vld (dec.valu && in_swr_vld),
        .probe_idx (in_swr),
        .probe_ex  (1'b0),
        .hit       (hit_smemval)
    );

    always_comb begin
        base = st_q;
        if (blk_start) begin
            base.vcmp = 1'b0;
            base.exw  = 1'b0;
            base.pv   = 1'b0;
            base.pd   = 1'b0;
            base.vb   = 1'b0;
            base.db   = 1'b0;
        end

        raw              = '0;
        raw[RB_MEMSCAL]  = hit_memscal;
        raw[RB_SMEMVAL]  = hit_smemval;
        raw[RB_CMPPERM]  = in_valid && dec.perm && base.vcmp;
        raw[RB_EXECWAR]  = in_valid && dec.valu && in_exec_wr && base.exw;
        raw[RB_LDSBR]    = in_valid && ((dec.ds && base.vb) || (dec.vmx && base.db));
        raw[RB_BROFS]    = in_valid && dec.branch && (in_offset == BAD_BR_OFS[OFS_W-1:0]);
        raw[RB_FLATOFS]  = in_valid && dec.flat && (in_imm[FLAT_OFS_W-1:0] != '0);

        st_d     = base;
        st_d.haz = '0;
        if (in_valid) begin
            st_d.haz = raw & (~raw + 1'b1);

            if (dec.vcmp) begin
                st_d.vcmp = 1'b1;
            end else if (dec.valu && !dec.vnop) begin
                st_d.vcmp = 1'b0;
            end

            if ((dec.valu && in_swr_vld) || dec.dep_clear) begin
                st_d.exw = 1'b0;
            end else if (!dec.valu && in_exec_rd) begin
                st_d.exw = 1'b1;
            end

            if (dec.vs_zero) begin
                st_d.pv = 1'b0;
                st_d.pd = 1'b0;
                st_d.vb = 1'b0;
                st_d.db = 1'b0;
            end else begin
                if (dec.branch) begin
                    st_d.vb = base.vb || base.pv;
                    st_d.db = base.db || base.pd;
                end
                if (dec.vmx) begin
                    st_d.pv = 1'b1;
                end
                if (dec.ds) begin
                    st_d.pd = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hazard = st_q.haz;

endmodule

// File: rtl/hz_checker_sva.sv
module hz_checker_sva
    import hz_pkg::*;
#(
    parameter int OFS_W      = 16,
    parameter int IMM_W      = 16,
    parameter int FLAT_OFS_W = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [CLS_W-1:0]     in_class,
    input logic [OFS_W-1:0]     in_offset,
    input logic [IMM_W-1:0]     in_imm,
    input logic [NUM_RULES-1:0] hazard
);
    // R1: an empty cycle yields no flag on the following cycle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (hazard == '0));

    // R1: program-control instructions complete no rule
    a_r1_sopp_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 5'd7) |=> (hazard == '0));

    // R7: a branch at the forbidden offset always raises some flag
    a_r7_branch_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 5'd8 && in_offset == 16'h003F) |=> (hazard != '0));

    // R8: FLAT with nonzero immediate offset always raises some flag
    a_r8_flat_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 5'd11 && in_imm[FLAT_OFS_W-1:0] != '0) |=> (hazard != '0));

    // R9: a reset cycle leaves the output clear
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (hazard == '0));

    // R10: never more than one flag
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hazard));

endmodule

bind hz_checker hz_checker_sva #(
    .OFS_W      (OFS_W),
    .IMM_W      (IMM_W),
    .FLAT_OFS_W (FLAT_OFS_W)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_offset (in_offset),
    .in_imm    (in_imm),
    .hazard    (hazard)
);

// File: tb/hz_checker_test.sv
`timescale 1ns/1ps
module hz_checker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_class = '0;
    logic        in_srd_vld = 1'b0;
    logic [6:0]  in_srd = '0;
    logic        in_swr_vld = 1'b0;
    logic [6:0]  in_swr = '0;
    logic        in_exec_rd = 1'b0;
    logic        in_exec_wr = 1'b0;
    logic [15:0] in_offset = '0;
    logic [15:0] in_imm = '0;
    logic [6:0]  hazard;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_mr [0:127];
    bit m_sm [0:127];
    bit m_mex, m_vcmp, m_exw, m_pv, m_pd, m_vb, m_db;

    always #2.5 clk = ~clk;

    hz_checker uut (
        .clk(clk), .rst(rst), .blk_start(blk_start), .in_valid(in_valid),
        .in_class(in_class), .in_srd_vld(in_srd_vld), .in_srd(in_srd),
        .in_swr_vld(in_swr_vld), .in_swr(in_swr), .in_exec_rd(in_exec_rd),
        .in_exec_wr(in_exec_wr), .in_offset(in_offset), .in_imm(in_imm),
        .hazard(hazard)
    );

    task automatic m_clear();
        for (int i = 0; i < 128; i++) begin
            m_mr[i] = 0;
            m_sm[i] = 0;
        end
        m_mex = 0; m_vcmp = 0; m_exw = 0;
        m_pv = 0; m_pd = 0; m_vb = 0; m_db = 0;
    endtask

    function automatic bit is_valu(int c);   return c <= 3;                     endfunction
    function automatic bit is_mem(int c);    return c >= 10 && c <= 14;         endfunction
    function automatic bit is_vmx(int c);    return c == 10 || c == 12 || c == 13; endfunction
    function automatic bit is_wait(int c);   return c >= 15 && c <= 18;         endfunction
    function automatic bit is_swrite(int c); return (c >= 4 && c <= 6) || c == 9; endfunction

    // model one accepted instruction, return the expected flag vector
    task automatic m_step(input int c, input bit rdv, input int rd, input bit wrv, input int wr,
                          input bit exr, input bit exw, input int off, input int imm,
                          output logic [6:0] e);
        logic [6:0] r;
        r = '0;
        r[0] = is_swrite(c) && ((wrv && m_mr[wr]) || (exw && m_mex));
        r[1] = is_valu(c) && wrv && m_sm[wr];
        r[2] = (c == 3) && m_vcmp;
        r[3] = is_valu(c) && exw && m_exw;
        r[4] = (c == 14 && m_vb) || (is_vmx(c) && m_db);
        r[5] = (c == 8) && (off == 'h3F);
        r[6] = (c == 11) && ((imm & 'hFFF) != 0);
        e = r & (~r + 7'd1);
        if (is_valu(c) || is_wait(c)) begin
            for (int i = 0; i < 128; i++) m_mr[i] = 0;
            m_mex = 0;
        end
        if (is_mem(c) && rdv) m_mr[rd] = 1;
        if (is_mem(c) && exr) m_mex = 1;
        if (c == 4 || c == 15) for (int i = 0; i < 128; i++) m_sm[i] = 0;
        if (c == 9 && rdv) m_sm[rd] = 1;
        if (c == 2) m_vcmp = 1;
        else if (is_valu(c) && c != 1) m_vcmp = 0;
        if ((is_valu(c) && wrv) || (c == 18 && imm == 'hFFFE)) m_exw = 0;
        else if (!is_valu(c) && exr) m_exw = 1;
        if (c == 17 && imm == 0) begin
            m_pv = 0; m_pd = 0; m_vb = 0; m_db = 0;
        end else begin
            if (c == 8) begin
                m_vb = m_vb | m_pv;
                m_db = m_db | m_pd;
            end
            if (is_vmx(c)) m_pv = 1;
            if (c == 14) m_pd = 1;
        end
    endtask

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: hazard=%b expected=%b", tag, got, exp);
        end
    endtask

    // drive one descriptor on the falling edge, sample after the next rising edge
    task automatic send(input int c, input bit rdv, input int rd, input bit wrv, input int wr,
                        input bit exr, input bit exw, input int off, input int imm,
                        input bit blk, input int expv, input string tag);
        logic [6:0] e;
        @(negedge clk);
        in_valid = 1; blk_start = blk; in_class = c[4:0];
        in_srd_vld = rdv; in_srd = rd[6:0]; in_swr_vld = wrv; in_swr = wr[6:0];
        in_exec_rd = exr; in_exec_wr = exw; in_offset = off[15:0]; in_imm = imm[15:0];
        if (blk) m_clear();
        m_step(c, rdv, rd, wrv, wr, exr, exw, off, imm, e);
        @(posedge clk); #1;
        blk_start = 0;
        if (tag != "") check(tag, hazard, (expv < 0) ? e : expv[6:0]);
    endtask

    task automatic op(input int c, input bit blk, input int expv, input string tag);
        send(c, 0, 0, 0, 0, 0, 0, 0, 0, blk, expv, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: hazard=%b expected=completion", hazard);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset state", hazard, 7'b0);
        @(negedge clk); rst = 0;

        // R2 memory read then scalar write
        send(10, 1, 5, 0, 0, 0, 0, 0, 0, 1, 0, "");
        send(4, 0, 0, 1, 5, 0, 0, 0, 0, 0, 'h01, "R2 vmem rd s5 then salu wr s5");
        send(10, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, "");
        op(0, 0, 0, "");
        send(4, 0, 0, 1, 5, 0, 0, 0, 0, 0, 'h00, "R2 valu clears");
        send(14, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, "");
        send(9, 0, 0, 0, 0, 0, 1, 0, 0, 0, 'h01, "R2 ds reads exec, smem writes exec");
        send(10, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, "");
        send(16, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, "");
        send(4, 0, 0, 1, 5, 0, 0, 0, 0, 0, 'h00, "R2 wait clears");
        send(10, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, "");
        send(4, 0, 0, 1, 6, 0, 0, 0, 0, 0, 'h00, "R2 other index no hit");

        // R3 scalar memory read then vector write
        send(9, 1, 3, 0, 0, 0, 0, 0, 0, 1, 0, "");
        op(5, 0, 0, ""); op(6, 0, 0, ""); op(16, 0, 0, "");
        send(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 'h02, "R3 skip/version/other wait do not clear");
        send(9, 1, 3, 0, 0, 0, 0, 0, 0, 1, 0, "");
        op(4, 0, 0, "");
        send(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 'h00, "R3 salu clears");
        send(9, 1, 3, 0, 0, 0, 0, 0, 0, 1, 0, "");
        op(15, 0, 0, "");
        send(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 'h00, "R3 lgkm wait clears");

        // R4 compare then permlane
        op(2, 1, 0, ""); op(1, 0, 0, "");
        op(3, 0, 'h04, "R4 vnop does not clear");
        op(2, 0, 0, ""); op(0, 0, 0, "");
        op(3, 0, 'h00, "R4 valu clears");

        // R5 EXEC read then EXEC write
        send(4, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, "");
        send(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 'h08, "R5 salu reads exec, valu writes exec");
        send(4, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");
        send(0, 0, 0, 1, 9, 0, 0, 0, 0, 0, 0, "");
        send(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 'h00, "R5 valu with sdst clears");
        send(4, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");
        send(18, 0, 0, 0, 0, 0, 0, 0, 'hFFFE, 0, 0, "");
        send(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 'h00, "R5 depctr 0xFFFE clears");
        send(4, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");
        send(18, 0, 0, 0, 0, 0, 0, 0, 'hFFFF, 0, 0, "");
        send(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 'h08, "R5 depctr 0xFFFF does not clear");

        // R6 memory / branch / LDS
        op(10, 1, 0, ""); op(8, 0, 0, "");
        op(14, 0, 'h10, "R6 vmem branch ds");
        op(14, 1, 0, ""); op(8, 0, 0, "");
        op(12, 0, 'h10, "R6 ds branch global");
        op(13, 1, 0, ""); op(8, 0, 0, "");
        send(17, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "");
        op(14, 0, 'h10, "R6 nonzero vscnt does not clear");
        op(10, 1, 0, ""); op(8, 0, 0, "");
        send(17, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        op(14, 0, 'h00, "R6 vscnt zero clears");
        op(10, 1, 0, "");
        op(14, 0, 'h00, "R6 no branch no hazard");

        // R7 branch offset
        send(8, 0, 0, 0, 0, 0, 0, 'h3F, 0, 1, 'h20, "R7 branch at 0x3F");
        send(8, 0, 0, 0, 0, 0, 0, 'h40, 0, 1, 'h00, "R7 branch at 0x40");
        send(7, 0, 0, 0, 0, 0, 0, 'h3F, 0, 0, 'h00, "R7 non-branch at 0x3F");

        // R8 FLAT immediate
        send(11, 0, 0, 0, 0, 0, 0, 0, 'h004, 1, 'h40, "R8 flat imm 4");
        send(11, 0, 0, 0, 0, 0, 0, 0, 'h000, 0, 'h00, "R8 flat imm 0");
        send(12, 0, 0, 0, 0, 0, 0, 0, 'h004, 0, 'h00, "R8 global imm 4");
        send(13, 0, 0, 0, 0, 0, 0, 0, 'h800, 0, 'h00, "R8 scratch imm 0x800");
        send(11, 0, 0, 0, 0, 0, 0, 0, 'h1000, 0, 'h00, "R8 flat bit 12 ignored");

        // R9 block start and reset flush
        send(10, 1, 5, 0, 0, 0, 0, 0, 0, 1, 0, "");
        send(4, 0, 0, 1, 5, 0, 0, 0, 0, 1, 'h00, "R9 block start flushes");
        op(2, 0, 0, "");
        @(negedge clk); rst = 1; in_valid = 0;
        @(posedge clk); #1;
        check("R9 output cleared by reset", hazard, 7'b0);
        @(negedge clk); rst = 0;
        m_clear();
        op(3, 0, 'h00, "R9 reset flushes pending");

        // R10 priority
        op(2, 1, 0, "");
        send(4, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");
        op(2, 0, 0, "");
        send(3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 'h04, "R10 permlane and exec write, lowest bit wins");

        // R1 idle
        idle();
        check("R1 idle cycle", hazard, 7'b0);

        // constrained random stream against the model
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 4000; n++) begin
            int c, rd, wr, off, imm, sel;
            bit blk;
            sel = $urandom_range(0, 39);
            if (sel == 0) begin
                idle();
                check("R1 random idle", hazard, 7'b0);
            end else begin
                c   = $urandom_range(0, 18);
                rd  = $urandom_range(0, 7);
                wr  = $urandom_range(0, 7);
                off = ($urandom_range(0, 5) == 0) ? 'h3F : $urandom_range(0, 'h7F);
                case ($urandom_range(0, 3))
                    0: imm = 0;
                    1: imm = 'hFFFE;
                    2: imm = $urandom_range(0, 3);
                    default: imm = $urandom_range(0, 'hFFFF);
                endcase
                blk = ($urandom_range(0, 31) == 0);
                send(c, $urandom_range(0, 1), rd, $urandom_range(0, 1), wr,
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                     off, imm, blk, -1, "R2-R10 random stream");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule